// File: doc/BRIEF.md
# Tick-Driven Two-Bit Watchdog

This block is a small watchdog for a low-power microcontroller. A slow periodic tick, nominally 1 Hz, is brought into the system clock domain. Each rising edge of the tick advances a two-bit count by one. If software does not clear the count in time, the block raises a reset request. The request is meant to drive the system reset, and that reset clears the watchdog again.

Software uses a 4-bit register port:
- bit 3 is a self-clearing "kick" bit;
- bit 2 is a sleep-enable flag that the block only stores and returns;
- bits 1 and 0 return the live count.

A separate inhibit input, driven from another control register, holds the count at zero and blocks the request. The counter is a four-state machine with these states:
- `CNT_ZERO`, `CNT_ONE`, `CNT_TWO` and `CNT_LAST`.

It has these transitions:
- **ADVANCE**: a tick edge moves to the next state.
- **EXPIRE**: a tick edge in `CNT_LAST` returns to `CNT_ZERO` and fires the request.
- **CLEAR**: a software kick moves to `CNT_ZERO`.
- **HOLD**: inhibit active moves to `CNT_ZERO`.
- **STAY**: with none of the above, the state does not change.

Top module: `tick_watchdog`

## Requirements
- R1: After asynchronous reset, the count is 00, all read data bits are 0 and `wdt_rst_req` is low.
- R2: Each rising edge of `slow_tick` advances the count 00→01→10→11. The count changes at the third `clk` rising edge after `slow_tick` rises. A tick held high does not advance it further.
- R3: A tick edge while the count is 11 (the fourth tick after a clear) raises `wdt_rst_req` and returns the count to 00.
- R4: `wdt_rst_req` is high for exactly one `clk` cycle per timeout.
- R5: A write with `reg_wdata[3]`=1 sets the count to 00 in the next cycle. Counting resumes from 00. `reg_rdata[3]` always reads 0.
- R6: A write with `reg_wdata[3]`=0 leaves the count unchanged.
- R7: `reg_wdata[2]` is stored on every write and returned on `reg_rdata[2]`. Its reset value is 0.
- R8: `reg_rdata[1:0]` returns the count, high bit in bit 1. Written values in bits 1:0 are ignored.
- R9: While `wdt_inhibit` is high, the count is held at 00 and no reset request is raised.
- R10: If a kick and a tick edge land in the same `clk` cycle, the kick wins and the count becomes 00 with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| slow_tick | input | 1 | Slow periodic tick, asynchronous to `clk` |
| wdt_inhibit | input | 1 | Holds the watchdog idle while high |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 4 | Register write data |
| reg_rdata | output | 4 | Register read data {0, sleep, count[1:0]} |
| wdt_rst_req | output | 1 | One-cycle reset request |

## Verification
A software kick and a synchronised tick edge can fall in the same system clock cycle. The bench first walks the count up to 11, so that the tick on its own would expire the watchdog. It then raises the tick and times the kick write to land in the one cycle where the internal advance pulse is high. The result is judged at the ports: the count must read 00 and the reset-request counter must not have moved.

// File: rtl/wd_pkg.sv
package wd_pkg;
    localparam int CNT_W = 2;
    localparam int REG_W = 4;
    localparam int KICK_BIT  = 3;
    localparam int SLEEP_BIT = 2;

    typedef enum logic [CNT_W-1:0] {
        CNT_ZERO = 2'd0,
        CNT_ONE  = 2'd1,
        CNT_TWO  = 2'd2,
        CNT_LAST = 2'd3
    } wd_state_t;
endpackage

// File: rtl/wd_tick_edge.sv
module wd_tick_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    output logic step
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Synchroniser chain, one flop per stage
    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= tick_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[STAGES-1];
    end

    assign step = sync_q[STAGES-1] & ~last_q;

    // R2: an advance pulse never lasts two cycles
    step_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> !step);
endmodule

// File: rtl/wd_count_fsm.sv
module wd_count_fsm
    import wd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             kick,
    input  logic             inhibit,
    output logic [CNT_W-1:0] count,
    output logic             rst_req
);
    wd_state_t state_q, state_d;
    logic      expire;

    always_comb begin
        state_d = state_q;
        expire  = 1'b0;
        if (inhibit) begin
            state_d = CNT_ZERO;                  // HOLD
        end else if (kick) begin
            state_d = CNT_ZERO;                  // CLEAR (wins over a tick)
        end else if (step) begin
            unique case (state_q)
                CNT_ZERO: state_d = CNT_ONE;     // ADVANCE
                CNT_ONE:  state_d = CNT_TWO;     // ADVANCE
                CNT_TWO:  state_d = CNT_LAST;    // ADVANCE
                CNT_LAST: begin
                    state_d = CNT_ZERO;          // EXPIRE
                    expire  = 1'b1;
                end
                default:  state_d = CNT_ZERO;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CNT_ZERO;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_req <= 1'b0;
        else        rst_req <= expire;
    end

    assign count = state_q;

    // R4
    req_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
    // R3
    req_from_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> ($past(state_q) == CNT_LAST && state_q == CNT_ZERO));
    // R9
    inhibit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |=> (state_q == CNT_ZERO && !rst_req));
    // R5
    kick_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (state_q == CNT_ZERO && !rst_req));
endmodule

// File: rtl/wd_csr.sv
module wd_csr
    import wd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    input  logic [CNT_W-1:0] count,
    output logic [REG_W-1:0] rdata,
    output logic             kick
);
    logic sleep_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  sleep_q <= 1'b0;
        else if (we) sleep_q <= wdata[SLEEP_BIT];
    end

    assign kick  = we & wdata[KICK_BIT];
    assign rdata = {1'b0, sleep_q, count};

    // R7
    sleep_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(sleep_q));
endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog
    import wd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_tick,
    input  logic             wdt_inhibit,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             wdt_rst_req
);
    logic             step;
    logic             kick;
    logic [CNT_W-1:0] count;

    wd_tick_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .tick_in(slow_tick), .step(step)
    );

    wd_count_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .step(step), .kick(kick),
        .inhibit(wdt_inhibit), .count(count), .rst_req(wdt_rst_req)
    );

    wd_csr u_csr (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .wdata(reg_wdata),
        .count(count), .rdata(reg_rdata), .kick(kick)
    );
endmodule

// File: tb/sim_tick_watchdog.sv
module sim_tick_watchdog;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_tick = 1'b0;
    logic       wdt_inhibit = 1'b0;
    logic       reg_we = 1'b0;
    logic [3:0] reg_wdata = 4'd0;
    logic [3:0] reg_rdata;
    logic       wdt_rst_req;

    int n_chk = 0;
    int n_fail = 0;
    int req_total = 0;
    int req_wide = 0;
    logic req_prev = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tick_watchdog u0 (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wdt_inhibit(wdt_inhibit),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .wdt_rst_req(wdt_rst_req)
    );

    always @(posedge clk) begin
        if (wdt_rst_req) req_total <= req_total + 1;
        if (wdt_rst_req && req_prev) req_wide <= req_wide + 1;
        req_prev <= wdt_rst_req;
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_tick();
        @(negedge clk) slow_tick = 1'b1;
        repeat (5) @(negedge clk);
        slow_tick = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_write(input logic [3:0] d);
        @(negedge clk) begin reg_we = 1'b1; reg_wdata = d; end
        @(negedge clk) begin reg_we = 1'b0; reg_wdata = 4'd0; end
        repeat (2) @(negedge clk);
    endtask

    // {op[1:0], wdata[3:0], exp_rdata[3:0], exp_req_total[3:0]}
    // op: 0 tick, 1 write, 2 inhibit on, 3 inhibit off
    localparam int NV = 19;
    localparam logic [13:0] VEC [NV] = '{
        {2'd0, 4'h0, 4'h1, 4'd0},  // R2
        {2'd0, 4'h0, 4'h2, 4'd0},  // R2
        {2'd0, 4'h0, 4'h3, 4'd0},  // R2
        {2'd1, 4'h8, 4'h0, 4'd0},  // R5 kick
        {2'd0, 4'h0, 4'h1, 4'd0},  // R5 resumes
        {2'd1, 4'h0, 4'h1, 4'd0},  // R6
        {2'd1, 4'h7, 4'h5, 4'd0},  // R7 sleep set, R8 bits1:0 ignored
        {2'd0, 4'h0, 4'h6, 4'd0},
        {2'd0, 4'h0, 4'h7, 4'd0},
        {2'd0, 4'h0, 4'h4, 4'd1},  // R3 fourth tick after kick
        {2'd1, 4'hC, 4'h4, 4'd1},  // R5 R7
        {2'd2, 4'h0, 4'h4, 4'd1},  // R9
        {2'd0, 4'h0, 4'h4, 4'd1},  // R9
        {2'd0, 4'h0, 4'h4, 4'd1},
        {2'd0, 4'h0, 4'h4, 4'd1},
        {2'd0, 4'h0, 4'h4, 4'd1},  // R9 no request
        {2'd3, 4'h0, 4'h4, 4'd1},
        {2'd0, 4'h0, 4'h5, 4'd1},
        {2'd1, 4'h3, 4'h1, 4'd1}   // R7 cleared, R8
    };

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 rdata", int'(reg_rdata), 0);
        check("R1 req", int'(wdt_rst_req), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [13:0] v;
            v = VEC[i];
            unique case (v[13:12])
                2'd0: do_tick();
                2'd1: do_write(v[11:8]);
                2'd2: begin wdt_inhibit = 1'b1; repeat (2) @(negedge clk); end
                default: begin wdt_inhibit = 1'b0; repeat (2) @(negedge clk); end
            endcase
            check($sformatf("vec%0d rdata", i), int'(reg_rdata), int'(v[7:4]));
            check($sformatf("vec%0d req", i), req_total, int'(v[3:0]));
        end

        // R2: latency of three clk edges, held tick does not re-advance
        @(negedge clk) slow_tick = 1'b1;
        repeat (2) @(negedge clk);
        check("R2 before third edge", int'(reg_rdata[1:0]), 1);
        @(negedge clk);
        check("R2 third edge", int'(reg_rdata[1:0]), 2);
        repeat (10) @(negedge clk);
        check("R2 held level", int'(reg_rdata[1:0]), 2);
        slow_tick = 1'b0;
        repeat (3) @(negedge clk);

        // R10: kick in the same cycle as the advance pulse, from count 11
        do_tick();
        check("R10 setup", int'(reg_rdata[1:0]), 3);
        @(negedge clk) slow_tick = 1'b1;
        @(negedge clk);
        @(negedge clk) begin reg_we = 1'b1; reg_wdata = 4'h8; end
        @(negedge clk) begin reg_we = 1'b0; reg_wdata = 4'h0; end
        repeat (6) @(negedge clk);
        slow_tick = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 count", int'(reg_rdata[1:0]), 0);
        check("R10 no request", req_total, 1);

        // R5: periodic kicks keep the watchdog quiet
        for (int k = 0; k < 10; k++) begin
            do_tick();
            do_write(4'h8);
        end
        check("R5 periodic no request", req_total, 1);

        // R3: timeout from a clean start lands on the fourth tick
        repeat (3) do_tick();
        check("R3 three ticks", req_total, 1);
        do_tick();
        check("R3 fourth tick", req_total, 2);
        check("R4 pulse width", req_wide, 0);

        // R1: asynchronous reset mid-count
        do_tick(); do_write(4'h4);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset", int'(reg_rdata), 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule